// File: doc/BRIEF.md
# Ping-pong transmit buffer controller

This block holds outgoing frames for a simple Ethernet transmitter. It has one or two transmit buffers, chosen by a build parameter. Each buffer is a word RAM with its own length and status registers, and all of them sit behind a 32-bit register port. Software does four things to send a frame:

- writes the frame bytes into a buffer;
- writes the byte count into that buffer's length register;
- sets the buffer's busy bit;
- waits for the busy bit to drop, or for the completion interrupt.

The block then streams the buffer's bytes out one at a time on a byte-wide valid/ready stream and clears busy when the last byte is accepted. Preamble, FCS and the physical interface belong to the stage downstream of the stream.

Stream rules: while `tx_valid` is high and `tx_ready` is low, `tx_data` and `tx_last` hold their values. A byte is accepted on any clock edge where both `tx_valid` and `tx_ready` are high. The downstream side may hold `tx_ready` low for any number of cycles.

A status command can also turn a buffer into a station-address load. When it is written, the first six buffer bytes go into the station address output instead of being sent. If both buffers are armed, they are served in the order in which they were armed.

Top module: `txpp_ctrl`

## Requirements
- R1: After reset, every status register, every length register and the global enable read 0. `tx_valid`, `irq` and `station_addr` are 0.
- R2: Buffer words are packed little-endian, and the byte in bits 7:0 of a word goes out first. A frame is exactly the buffer's first N bytes in address order. `tx_last` is high only on byte N-1.
- R3: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` stay unchanged on the next cycle.
- R4: Writing 1 to status bit 0 (busy) of an idle buffer starts a send. Busy reads 1 until the last byte is accepted, and reads 0 from the cycle after.
- R5: `irq` is a one-cycle pulse in the cycle after a buffer's busy bit falls. It fires only if that buffer's status bit 3 and bit 31 of the global enable register (byte offset 0x7F8 of the first window) are both 1.
- R6: Writing status bits 0 and 1 together loads `station_addr` from buffer bytes 0..5, with byte 0 in bits 47:40 and byte 5 in bits 7:0. Nothing appears on the stream, and both bits then read 0.
- R7: Status bit 31 reads back as last written and has no effect on sending or interrupts.
- R8: The second buffer's registers and RAM sit at byte offset 0x800 from the first. Status is at window offset 0x7FC, length at 0x7F4, and buffer word k at 4k. When both buffers are busy, they are sent in the order in which their busy bits were set.
- R9: While a buffer is busy, writes to its status bits 0 and 1 are ignored: busy stays set and the frame is sent only once.
- R10: The length register keeps the low 16 bits written. The number of bytes sent is the smaller of that value and 1514. A length of 0 sends nothing, and busy still clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register/RAM write strobe |
| reg_addr | input | 12 | Byte address; bit 11 selects the buffer window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (same cycle) |
| tx_data | output | 8 | Outgoing frame byte |
| tx_valid | output | 1 | `tx_data` is valid |
| tx_ready | input | 1 | Downstream accepts the byte |
| tx_last | output | 1 | Current byte ends the frame |
| irq | output | 1 | One-cycle completion pulse |
| station_addr | output | 48 | Loaded station address |

## Verification
The bench goes after the following corner cases, each with the failure it would expose:

- **Back-pressure under a random ready pattern.** A design that advanced its byte pointer without a handshake would skip or repeat bytes.
- **Both buffers armed while the stream is held off, in reverse window order.** A fixed-priority design would send the first window first.
- **Busy written again during a send.** A design that did not ignore it would send the frame twice.
- **A 2000-byte length.** A design that did not clamp it would run past the buffer.
- **A zero length.** A design without the zero-length case would hang with busy set.
- **An address-load command.** A design that treated it as a send would emit bytes onto the stream.
- **An interrupt with the global enable off.** Here the pulse must be missing.
- **The software flag bit.** It must read back as written and start nothing.

// File: rtl/txpp_pkg.sv
package txpp_pkg;
  localparam logic [10:0] OFF_LEN  = 11'h7F4;
  localparam logic [10:0] OFF_GIE  = 11'h7F8;
  localparam logic [10:0] OFF_STAT = 11'h7FC;

  localparam int ST_BUSY = 0;
  localparam int ST_PROG = 1;
  localparam int ST_IE   = 3;
  localparam int ST_FLAG = 31;

  typedef enum logic [2:0] {
    S_IDLE, S_SEND, S_MAC0, S_MAC1, S_FIN
  } tx_state_e;
endpackage

// File: rtl/txpp_bank.sv
module txpp_bank
  import txpp_pkg::*;
#(
  parameter int WORDS = 379,
  parameter int IDX_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [10:0]      off,
  input  logic [31:0]      wdata,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             done_i,
  output logic             busy,
  output logic             prog,
  output logic             ie,
  output logic [15:0]      len,
  output logic [31:0]      rd_val,
  output logic [31:0]      rd_word,
  output logic             arm
);
  logic [31:0] mem [WORDS];
  logic        flag;
  logic        stat_we, len_we, mem_we;

  assign stat_we = we && (off == OFF_STAT);
  assign len_we  = we && (off == OFF_LEN);
  assign mem_we  = we && (int'(off[10:2]) < WORDS);
  assign arm     = stat_we && !busy && wdata[ST_BUSY];

  always_ff @(posedge clk) begin
    if (mem_we) mem[IDX_W'(off[10:2])] <= wdata;
  end
  assign rd_word = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      prog <= 1'b0;
      ie   <= 1'b0;
      flag <= 1'b0;
      len  <= '0;
    end else begin
      if (done_i) begin
        busy <= 1'b0;
        prog <= 1'b0;
      end
      if (stat_we) begin
        ie   <= wdata[ST_IE];
        flag <= wdata[ST_FLAG];
        if (!busy) begin
          busy <= wdata[ST_BUSY];
          prog <= wdata[ST_BUSY] & wdata[ST_PROG];
        end
      end
      if (len_we) len <= wdata[15:0];
    end
  end

  always_comb begin
    rd_val = '0;
    if (off == OFF_STAT) begin
      rd_val[ST_BUSY] = busy;
      rd_val[ST_PROG] = prog;
      rd_val[ST_IE]   = ie;
      rd_val[ST_FLAG] = flag;
    end else if (off == OFF_LEN) begin
      rd_val[15:0] = len;
    end
  end

  // R4
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done_i));
  // R6
  prog_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog |-> busy);
  // R9
  rearm_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && stat_we && !done_i) |=> busy);
endmodule

// File: rtl/txpp_sched.sv
module txpp_sched
  import txpp_pkg::*;
#(
  parameter int NUM_BUF = 2,
  parameter int MAX_LEN = 1514,
  parameter int IDX_W   = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_BUF-1:0] arm,
  input  logic [NUM_BUF-1:0] prog,
  input  logic [15:0]        len     [NUM_BUF],
  input  logic [31:0]        rd_word [NUM_BUF],
  input  logic               tx_ready,
  output logic               tx_valid,
  output logic [7:0]         tx_data,
  output logic               tx_last,
  output logic [NUM_BUF-1:0] done,
  output logic [IDX_W-1:0]   rd_idx,
  output logic [47:0]        station_addr
);
  localparam int BSEL_W = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1;
  localparam int CNT_W  = $clog2(NUM_BUF + 1);

  tx_state_e         state;
  logic [BSEL_W-1:0] q [NUM_BUF];
  logic [CNT_W-1:0]  cnt;
  logic [BSEL_W-1:0] cur, push_id, head;
  logic [15:0]       byte_cnt, limit, eff_len;
  logic [31:0]       w0, word_sel;
  logic              push, pop;
  logic [CNT_W-1:0]  pos;

  // arrival-order queue of armed buffers
  always_comb begin
    push_id = '0;
    for (int i = 0; i < NUM_BUF; i++)
      if (arm[i]) push_id = BSEL_W'(i);
  end
  assign push = |arm;
  assign pop  = (state == S_IDLE) && (cnt != '0);
  assign head = q[0];
  assign pos  = cnt - CNT_W'(pop);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      for (int i = 0; i < NUM_BUF; i++) q[i] <= '0;
    end else begin
      if (pop)
        for (int i = 0; i < NUM_BUF - 1; i++) q[i] <= q[i+1];
      if (push) q[pos[BSEL_W-1:0]] <= push_id;
      cnt <= cnt + CNT_W'(push) - CNT_W'(pop);
    end
  end

  assign eff_len  = (len[head] > 16'(MAX_LEN)) ? 16'(MAX_LEN) : len[head];
  assign word_sel = rd_word[cur];
  assign tx_valid = (state == S_SEND);
  assign tx_data  = word_sel[8*byte_cnt[1:0] +: 8];
  assign tx_last  = tx_valid && (byte_cnt == limit - 16'd1);

  always_comb begin
    case (state)
      S_MAC1:  rd_idx = IDX_W'(1);
      S_SEND:  rd_idx = byte_cnt[IDX_W+1:2];
      default: rd_idx = '0;
    endcase
  end

  always_comb begin
    done = '0;
    if ((state == S_SEND && tx_ready && tx_last) || state == S_MAC1 || state == S_FIN)
      done[cur] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      cur          <= '0;
      byte_cnt     <= '0;
      limit        <= '0;
      w0           <= '0;
      station_addr <= '0;
    end else begin
      case (state)
        S_IDLE: if (pop) begin
          cur      <= head;
          byte_cnt <= '0;
          limit    <= eff_len;
          if (prog[head])         state <= S_MAC0;
          else if (eff_len == '0) state <= S_FIN;
          else                    state <= S_SEND;
        end
        S_SEND: if (tx_ready) begin
          if (tx_last) state <= S_IDLE;
          else         byte_cnt <= byte_cnt + 16'd1;
        end
        S_MAC0: begin
          w0    <= word_sel;
          state <= S_MAC1;
        end
        S_MAC1: begin
          station_addr <= {w0[7:0], w0[15:8], w0[23:16], w0[31:24],
                           word_sel[7:0], word_sel[15:8]};
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R3
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));
  // R8
  queue_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) <= NUM_BUF);
  // R8
  one_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(done));
endmodule

// File: rtl/txpp_ctrl.sv
module txpp_ctrl
  import txpp_pkg::*;
#(
  parameter int NUM_BUF = 2,
  parameter int MAX_LEN = 1514
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [11:0] reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic [7:0]  tx_data,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic        tx_last,
  output logic        irq,
  output logic [47:0] station_addr
);
  localparam int WORDS = (MAX_LEN + 3) / 4;
  localparam int IDX_W = $clog2(WORDS);

  logic              win;
  logic [10:0]       off;
  logic              gie;
  logic [NUM_BUF-1:0] busy_v, prog_v, ie_v, arm_v, done_v;
  logic [15:0]       len_a   [NUM_BUF];
  logic [31:0]       rdv_a   [NUM_BUF];
  logic [31:0]       word_a  [NUM_BUF];
  logic [IDX_W-1:0]  rd_idx;

  assign win = reg_addr[11];
  assign off = reg_addr[10:0];

  for (genvar b = 0; b < NUM_BUF; b++) begin : g_bank
    txpp_bank #(.WORDS(WORDS), .IDX_W(IDX_W)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (reg_we && (int'(win) == b)),
      .off    (off),
      .wdata  (reg_wdata),
      .rd_idx (rd_idx),
      .done_i (done_v[b]),
      .busy   (busy_v[b]),
      .prog   (prog_v[b]),
      .ie     (ie_v[b]),
      .len    (len_a[b]),
      .rd_val (rdv_a[b]),
      .rd_word(word_a[b]),
      .arm    (arm_v[b])
    );
  end

  txpp_sched #(.NUM_BUF(NUM_BUF), .MAX_LEN(MAX_LEN), .IDX_W(IDX_W)) u_sched (
    .clk         (clk),
    .rst_n       (rst_n),
    .arm         (arm_v),
    .prog        (prog_v),
    .len         (len_a),
    .rd_word     (word_a),
    .tx_ready    (tx_ready),
    .tx_valid    (tx_valid),
    .tx_data     (tx_data),
    .tx_last     (tx_last),
    .done        (done_v),
    .rd_idx      (rd_idx),
    .station_addr(station_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gie <= 1'b0;
      irq <= 1'b0;
    end else begin
      if (reg_we && !win && off == OFF_GIE) gie <= reg_wdata[31];
      irq <= gie && |(done_v & ie_v);
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (!win && off == OFF_GIE) reg_rdata = {gie, 31'b0};
    else
      for (int b = 0; b < NUM_BUF; b++)
        if (int'(win) == b) reg_rdata = rdv_a[b];
  end

  // R5
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(gie));
  // R5
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  // R4
  busy_on_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> |busy_v);
endmodule

// File: tb/txpp_ctrl_tb.sv
module txpp_ctrl_tb;
  logic        clk = 0, rst_n = 0, reg_we = 0, tx_ready = 0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [7:0]  tx_data;
  logic        tx_valid, tx_last, irq;
  logic [47:0] station_addr;

  always #4 clk = ~clk;

  txpp_ctrl u_dut (.*);

  int checks = 0, errors = 0, irq_cnt = 0, rdy_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [7:0]  exp_q [$];
  bit          exp_last_q [$];
  bit          frm_irq_q [$];
  bit          irq_pend = 0, prev_stall = 0, prev_last = 0, gie_m = 0;
  logic [7:0]  prev_data = '0;
  int          st_len [2];
  int          st_seed [2];

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  function automatic logic [7:0] pat(int seed, int i);
    return 8'(seed + i * 7 + (i >> 8));
  endfunction

  // ready pattern: 0 always, 1 pseudo-random, 2 held low
  always @(posedge clk) begin
    #2;
    lfsr     <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    tx_ready <= (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? lfsr[0] : 1'b0;
  end

  // behavioural reference compared every cycle
  always @(negedge clk) begin
    if (prev_stall) begin
      chk("R3", "valid held", tx_valid, 1);
      chk("R3", "data held", tx_data, prev_data);
      chk("R3", "last held", tx_last, prev_last);
    end
    if (irq || irq_pend) chk("R5", "irq pulse", irq, irq_pend);
    if (irq) irq_cnt++;
    irq_pend = 0;
    if (tx_valid && tx_ready) begin
      if (exp_q.size() == 0) chk("R2", "unexpected byte", {1'b1, tx_data}, 0);
      else begin
        logic [7:0] e;
        bit el;
        e  = exp_q.pop_front();
        el = exp_last_q.pop_front();
        chk("R2", "byte", tx_data, e);
        chk("R2", "last flag", tx_last, el);
        if (el && frm_irq_q.size() > 0) irq_pend = frm_irq_q.pop_front();
      end
    end
    prev_stall = tx_valid && !tx_ready;
    prev_data  = tx_data;
    prev_last  = tx_last;
  end

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(posedge clk); #2;
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #2;
    reg_we = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(posedge clk); #2;
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic set_gie(bit g);
    wr(12'h7F8, {g, 31'b0});
    gie_m = g;
  endtask

  task automatic load(int b, int len, int seed);
    int n = (len > 1514) ? 1514 : len;
    for (int w = 0; w < (n + 3) / 4; w++)
      wr(12'(b * 12'h800 + w * 4),
         {pat(seed, 4*w+3), pat(seed, 4*w+2), pat(seed, 4*w+1), pat(seed, 4*w)});
    wr(12'(b * 12'h800 + 12'h7F4), 32'(len));
    st_len[b]  = n;
    st_seed[b] = seed;
  endtask

  task automatic arm(int b, bit ie);
    for (int i = 0; i < st_len[b]; i++) begin
      exp_q.push_back(pat(st_seed[b], i));
      exp_last_q.push_back(i == st_len[b] - 1);
    end
    if (st_len[b] > 0) frm_irq_q.push_back(ie && gie_m);
    wr(12'(b * 12'h800 + 12'h7FC), {28'b0, ie, 2'b0, 1'b1});
  endtask

  task automatic wait_idle(int b, string req);
    logic [31:0] s;
    int n = 0;
    do begin
      rd(12'(b * 12'h800 + 12'h7FC), s);
      n++;
    end while (s[0] && n < 20000);
    chk(req, "busy cleared", s[0], 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] v;
    int ic;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;

    // R1 reset state
    rd(12'h7FC, v); chk("R1", "status0", v, 0);
    rd(12'hFFC, v); chk("R1", "status1", v, 0);
    rd(12'h7F4, v); chk("R1", "len0", v, 0);
    rd(12'h7F8, v); chk("R1", "gie", v, 0);
    chk("R1", "tx_valid", tx_valid, 0);
    chk("R1", "irq", irq, 0);
    chk("R1", "station", station_addr, 0);

    // R2 R4 R5: single frame, random ready, interrupts on
    set_gie(1);
    rdy_mode = 1;
    load(0, 9, 8'h10);
    arm(0, 1);
    rd(12'h7FC, v); chk("R4", "busy after arm", v[0], 1);
    wait_idle(0, "R4");
    repeat (4) @(posedge clk);
    chk("R5", "irq count", irq_cnt, 1);
    chk("R2", "frame consumed", exp_q.size(), 0);

    // R5 per-buffer enable off: no pulse
    load(1, 6, 8'h33);
    arm(1, 0);
    wait_idle(1, "R5");
    repeat (4) @(posedge clk);
    chk("R5", "no irq with ie=0", irq_cnt, 1);

    // R9 re-arm during send is ignored
    rdy_mode = 2;
    load(0, 64, 8'h05);
    arm(0, 1);
    wr(12'h7FC, 32'h9);
    rd(12'h7FC, v); chk("R9", "busy after rewrite", v[0], 1);
    wr(12'h7FC, 32'h8);
    rd(12'h7FC, v); chk("R9", "busy after clear try", v[0], 1);
    rdy_mode = 1;
    wait_idle(0, "R9");
    repeat (30) @(posedge clk);
    chk("R9", "single send", exp_q.size(), 0);
    chk("R9", "one irq", irq_cnt, 2);

    // R8 arm order: window 1 first, then window 0
    rdy_mode = 2;
    load(1, 5, 8'h40);
    load(0, 7, 8'h80);
    arm(1, 1);
    arm(0, 0);
    rd(12'h7FC, v); chk("R8", "buf0 busy", v[0], 1);
    rd(12'hFFC, v); chk("R8", "buf1 busy", v[0], 1);
    rdy_mode = 0;
    wait_idle(0, "R8");
    wait_idle(1, "R8");
    repeat (4) @(posedge clk);
    chk("R8", "both sent", exp_q.size(), 0);
    chk("R8", "irq only from buf1", irq_cnt, 3);

    // R7 software flag
    wr(12'h7FC, 32'h8000_0000);
    repeat (20) @(posedge clk);
    rd(12'h7FC, v); chk("R7", "flag readback", v, 32'h8000_0000);
    wr(12'h7FC, 32'h0);
    rd(12'h7FC, v); chk("R7", "flag cleared", v, 0);

    // R5 global enable off
    set_gie(0);
    ic = irq_cnt;
    load(0, 3, 8'h70);
    arm(0, 1);
    wait_idle(0, "R5");
    repeat (4) @(posedge clk);
    chk("R5", "no irq with global off", irq_cnt, ic);

    // R6 station address load
    wr(12'h000, 32'h4433_2211);
    wr(12'h004, 32'h0000_6655);
    wr(12'h7FC, 32'h3);
    wait_idle(0, "R6");
    rd(12'h7FC, v); chk("R6", "bits cleared", v, 0);
    chk("R6", "station", station_addr, 48'h1122_3344_5566);
    repeat (10) @(posedge clk);

    // R10 length width and clamp, zero length
    wr(12'h7F4, 32'hABCD_05EA);
    rd(12'h7F4, v); chk("R10", "len 16 bits", v, 32'h05EA);
    set_gie(1);
    rdy_mode = 1;
    load(0, 2000, 8'h03);
    rd(12'h7F4, v); chk("R10", "len readback", v, 2000);
    arm(0, 1);
    wait_idle(0, "R10");
    repeat (4) @(posedge clk);
    chk("R10", "1514 bytes sent", exp_q.size(), 0);
    ic = irq_cnt;
    load(1, 0, 0);
    arm(1, 0);
    wait_idle(1, "R10");
    repeat (10) @(posedge clk);
    chk("R10", "zero length no irq", irq_cnt, ic);
    chk("R10", "zero length no bytes", tx_valid, 0);

    summary();
  end
endmodule